// File: doc/BRIEF.md
# Dual-Issue Operand Bypass Selector

This combinational block sits beside the decode stage of a two-wide in-order pipeline with three execute stages behind decode. For each of the two source operands of the oldest decoded instruction, it looks at the six in-flight results (three stages, two issue slots each) and decides whether the operand can take a result that is still in flight instead of the register-file value. If it can, it also decides which stage and slot supplies it. It does not generate stalls and does not hold state.

Operands and results are either short (one 16-bit register) or long (an even/odd register pair carried as 32 bits). Forwarding is restricted in three ways. A producer must be marked forward-capable. A two-cycle producer may be tapped only once it has left the first execute stage. The operand length must equal the result length. When several producers write the register, only the youngest one counts. If that one cannot be forwarded, the register-file value passes through and the bypass flag stays low.

Top module: `dual_issue_bypass_sel`

## Requirements
- R1: A producer is considered only when `dec_valid_i` is high, the operand's read-enable bit is high, and the producer's valid and write bits are both high.
- R2: When operand and producer have the same length, a match requires the operand register id to equal the destination id.
- R3: A long operand at id `a` meets a short producer at `d` when `d` is `a` or `a|1`. A short operand at `a` meets a long producer at `d` when `a` is `d` or `d|1`. Such a match counts as a hit for priority, but it is never forwarded.
- R4: A hit whose operand length differs from its producer length is never forwarded.
- R5: A producer whose forward-enable bit is low is never forwarded.
- R6: A two-cycle producer is never forwarded from the first execute stage (stage index 0). It may be forwarded from stage indices 1 and 2.
- R7: Among hits, the youngest wins. Lower stage index beats higher, and within a stage slot 1 beats slot 0. Select bit `k` stands for stage `k/2`, slot `k%2`.
- R8: If the youngest hit cannot be forwarded, the operand is not forwarded at all, even when an older hit could be.
- R9: On a bypass, a long operand receives the producer's full 32 bits, and a short operand receives `{16'b0, data[15:0]}`. Without a bypass, the select is all-zero and the register-file data passes through unchanged.
- R10: Each operand's select is one-hot or zero, and its bypass flag is high exactly when its select is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid_i | input | 1 | Decode-stage instruction valid |
| op_rd_en_i | input | 2 | Operand actually read (bit 0 = A, bit 1 = B) |
| op_long_i | input | 2 | Operand is a long (pair) operand |
| op_reg_i | input | 2x4 | Operand register ids |
| rf_data_i | input | 2x32 | Register-file read data per operand |
| prod_valid_i | input | 6 | In-flight slot valid, index stage*2+slot |
| prod_wr_i | input | 6 | In-flight slot writes a destination |
| prod_fwd_en_i | input | 6 | Producer result is forward-capable |
| prod_two_cyc_i | input | 6 | Producer is a two-cycle operation |
| prod_long_i | input | 6 | Producer writes a long result |
| prod_dst_i | input | 6x4 | Producer destination register id |
| prod_data_i | input | 6x32 | Producer result data |
| byp_sel_o | output | 2x6 | One-hot bypass source per operand |
| byp_valid_o | output | 2 | Operand is taken from a bypass |
| op_data_o | output | 2x32 | Resolved operand data |

## Verification
Directed patterns each isolate one rule:
- gating bits dropped one at a time;
- a two-cycle producer in the first and in the second stage;
- long/short pairings where the ids overlap only through the pair partner;
- a non-forwardable young hit that shadows a forwardable older one;
- simultaneous hits in both slots and across stages.

Random vectors use register ids drawn from a narrow range, so that multiple hits and mixed lengths are common. They exercise the priority and blocking interplay that the directed cases test only in isolation. Both operands are compared against a behavioural model on every vector.

// File: rtl/byp_pkg.sv
package byp_pkg;
  localparam int REG_ID_W = 4;
  localparam int SHORT_W  = 16;
  localparam int LONG_W   = 2 * SHORT_W;
  localparam int NUM_OPS  = 2;

  typedef logic [REG_ID_W-1:0] reg_id_t;
  typedef logic [LONG_W-1:0]   word_t;

  // partner register of an even-aligned pair
  function automatic reg_id_t pair_odd(reg_id_t r);
    return r | reg_id_t'(1);
  endfunction
endpackage

// File: rtl/byp_match.sv
module byp_match
  import byp_pkg::*;
#(
  parameter int STAGE_IDX = 0
) (
  input  logic    op_live_i,
  input  reg_id_t op_reg_i,
  input  logic    op_long_i,
  input  logic    valid_i,
  input  logic    wr_i,
  input  logic    fwd_en_i,
  input  logic    two_cyc_i,
  input  logic    long_i,
  input  reg_id_t dst_i,
  output logic    hit_o,
  output logic    ok_o
);
  logic id_eq, wide_op_eq, wide_res_eq;

  always_comb begin
    id_eq       = (op_reg_i == dst_i);
    wide_op_eq  = op_long_i && !long_i && (pair_odd(op_reg_i) == dst_i);
    wide_res_eq = long_i && !op_long_i && (op_reg_i == pair_odd(dst_i));
    hit_o = op_live_i && valid_i && wr_i && (id_eq || wide_op_eq || wide_res_eq);
    ok_o  = fwd_en_i && (op_long_i == long_i) && !(two_cyc_i && STAGE_IDX == 0);
  end
endmodule

// File: rtl/byp_pick.sv
module byp_pick #(
  parameter int NUM_STAGES = 3,
  parameter int NUM_SLOTS  = 2,
  localparam int NUM_SRC   = NUM_STAGES * NUM_SLOTS
) (
  input  logic [NUM_SRC-1:0] hit_i,
  input  logic [NUM_SRC-1:0] ok_i,
  output logic [NUM_SRC-1:0] sel_o,
  output logic               valid_o
);
  logic [NUM_SRC-1:0] win;
  logic               win_ok;

  // oldest to youngest, last hit overrides
  always_comb begin
    win    = '0;
    win_ok = 1'b0;
    for (int st = NUM_STAGES - 1; st >= 0; st--) begin
      for (int sl = 0; sl < NUM_SLOTS; sl++) begin
        if (hit_i[st*NUM_SLOTS+sl]) begin
          win                  = '0;
          win[st*NUM_SLOTS+sl] = 1'b1;
          win_ok               = ok_i[st*NUM_SLOTS+sl];
        end
      end
    end
    valid_o = win_ok;
    sel_o   = win_ok ? win : '0;
  end
endmodule

// File: rtl/byp_mux.sv
module byp_mux
  import byp_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic [NUM_SRC-1:0]             sel_i,
  input  logic                           valid_i,
  input  logic                           op_long_i,
  input  logic [NUM_SRC-1:0][LONG_W-1:0] prod_data_i,
  input  word_t                          rf_data_i,
  output word_t                          data_o
);
  word_t acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_SRC; k++) acc |= prod_data_i[k] & {LONG_W{sel_i[k]}};
    if (!valid_i)       data_o = rf_data_i;
    else if (op_long_i) data_o = acc;
    else                data_o = {{(LONG_W-SHORT_W){1'b0}}, acc[SHORT_W-1:0]};
  end
endmodule

// File: rtl/dual_issue_bypass_sel.sv
module dual_issue_bypass_sel
  import byp_pkg::*;
#(
  parameter int NUM_STAGES = 3,
  parameter int NUM_SLOTS  = 2,
  localparam int NUM_SRC   = NUM_STAGES * NUM_SLOTS
) (
  input  logic                                   dec_valid_i,
  input  logic [NUM_OPS-1:0]                     op_rd_en_i,
  input  logic [NUM_OPS-1:0]                     op_long_i,
  input  logic [NUM_OPS-1:0][REG_ID_W-1:0]       op_reg_i,
  input  logic [NUM_OPS-1:0][LONG_W-1:0]         rf_data_i,
  input  logic [NUM_SRC-1:0]                     prod_valid_i,
  input  logic [NUM_SRC-1:0]                     prod_wr_i,
  input  logic [NUM_SRC-1:0]                     prod_fwd_en_i,
  input  logic [NUM_SRC-1:0]                     prod_two_cyc_i,
  input  logic [NUM_SRC-1:0]                     prod_long_i,
  input  logic [NUM_SRC-1:0][REG_ID_W-1:0]       prod_dst_i,
  input  logic [NUM_SRC-1:0][LONG_W-1:0]         prod_data_i,
  output logic [NUM_OPS-1:0][NUM_SRC-1:0]        byp_sel_o,
  output logic [NUM_OPS-1:0]                     byp_valid_o,
  output logic [NUM_OPS-1:0][LONG_W-1:0]         op_data_o
);
  logic [NUM_OPS-1:0][NUM_SRC-1:0] hit, ok;

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    for (genvar st = 0; st < NUM_STAGES; st++) begin : g_st
      for (genvar sl = 0; sl < NUM_SLOTS; sl++) begin : g_sl
        localparam int K = st * NUM_SLOTS + sl;
        byp_match #(.STAGE_IDX(st)) u_match (
          .op_live_i (dec_valid_i && op_rd_en_i[op]),
          .op_reg_i  (op_reg_i[op]),
          .op_long_i (op_long_i[op]),
          .valid_i   (prod_valid_i[K]),
          .wr_i      (prod_wr_i[K]),
          .fwd_en_i  (prod_fwd_en_i[K]),
          .two_cyc_i (prod_two_cyc_i[K]),
          .long_i    (prod_long_i[K]),
          .dst_i     (prod_dst_i[K]),
          .hit_o     (hit[op][K]),
          .ok_o      (ok[op][K])
        );
      end
    end

    byp_pick #(.NUM_STAGES(NUM_STAGES), .NUM_SLOTS(NUM_SLOTS)) u_pick (
      .hit_i   (hit[op]),
      .ok_i    (ok[op]),
      .sel_o   (byp_sel_o[op]),
      .valid_o (byp_valid_o[op])
    );

    byp_mux #(.NUM_SRC(NUM_SRC)) u_mux (
      .sel_i       (byp_sel_o[op]),
      .valid_i     (byp_valid_o[op]),
      .op_long_i   (op_long_i[op]),
      .prod_data_i (prod_data_i),
      .rf_data_i   (rf_data_i[op]),
      .data_o      (op_data_o[op])
    );

    always_comb begin
      // R10
      sel_onehot_chk: assert ($onehot0(byp_sel_o[op]) && (byp_valid_o[op] == |byp_sel_o[op]));
      // R1
      dec_gate_chk: assert (dec_valid_i && op_rd_en_i[op] || !byp_valid_o[op]);
      // R5
      fwd_en_chk: assert ((byp_sel_o[op] & ~prod_fwd_en_i) == '0);
      // R6
      two_cyc_ix1_chk: assert ((byp_sel_o[op][NUM_SLOTS-1:0] & prod_two_cyc_i[NUM_SLOTS-1:0]) == '0);
      // R4
      len_match_chk: assert ((byp_sel_o[op] & (op_long_i[op] ? ~prod_long_i : prod_long_i)) == '0);
      // R9
      pass_thru_chk: assert (byp_valid_o[op] || op_data_o[op] == rf_data_i[op]);
    end
  end
endmodule

// File: tb/dual_issue_bypass_sel_bench.sv
module dual_issue_bypass_sel_bench;
  localparam int NSRC = 6;
  localparam int NOPS = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                       dec_valid;
  logic [NOPS-1:0]            op_rd_en, op_long;
  logic [NOPS-1:0][3:0]       op_reg;
  logic [NOPS-1:0][31:0]      rf_data;
  logic [NSRC-1:0]            p_valid, p_wr, p_fwd, p_two, p_long;
  logic [NSRC-1:0][3:0]       p_dst;
  logic [NSRC-1:0][31:0]      p_data;
  logic [NOPS-1:0][NSRC-1:0]  sel;
  logic [NOPS-1:0]            bvalid;
  logic [NOPS-1:0][31:0]      odata;

  int vectors = 0, errors = 0;
  bit done = 0;

  dual_issue_bypass_sel u_dual_issue_bypass_sel (
    .dec_valid_i(dec_valid), .op_rd_en_i(op_rd_en), .op_long_i(op_long),
    .op_reg_i(op_reg), .rf_data_i(rf_data), .prod_valid_i(p_valid),
    .prod_wr_i(p_wr), .prod_fwd_en_i(p_fwd), .prod_two_cyc_i(p_two),
    .prod_long_i(p_long), .prod_dst_i(p_dst), .prod_data_i(p_data),
    .byp_sel_o(sel), .byp_valid_o(bvalid), .op_data_o(odata)
  );

  // behavioural reference: scan youngest first, first hit decides
  task automatic model(input int op, output logic [NSRC-1:0] es, output logic ev,
                       output logic [31:0] ed);
    int a, d, win;
    bit h;
    win = -1;
    a = int'(op_reg[op]);
    for (int st = 0; st < 3 && win < 0; st++)
      for (int sl = 1; sl >= 0 && win < 0; sl--) begin
        int k = st * 2 + sl;
        d = int'(p_dst[k]);
        if (!(dec_valid && op_rd_en[op] && p_valid[k] && p_wr[k])) continue;
        if (op_long[op] == p_long[k]) h = (a == d);
        else if (op_long[op])         h = (d == a) || (d == (a | 1));
        else                          h = (a == d) || (a == (d | 1));
        if (h) win = k;
      end
    es = '0; ev = 0; ed = rf_data[op];
    if (win >= 0 && p_fwd[win] && (op_long[op] == p_long[win]) && !(p_two[win] && win < 2)) begin
      ev = 1;
      es[win] = 1'b1;
      ed = op_long[op] ? p_data[win] : {16'h0, p_data[win][15:0]};
    end
  endtask

  task automatic check(input string tag);
    logic [NSRC-1:0] es; logic ev; logic [31:0] ed;
    @(negedge clk);
    for (int op = 0; op < NOPS; op++) begin
      model(op, es, ev, ed);
      vectors++;
      if (sel[op] !== es || bvalid[op] !== ev || odata[op] !== ed) begin
        errors++;
        $display("FAIL %s op%0d: sel=%b v=%b d=%h expected sel=%b v=%b d=%h",
                 tag, op, sel[op], bvalid[op], odata[op], es, ev, ed);
      end
    end
  endtask

  task automatic clear();
    @(posedge clk); #1;
    dec_valid = 1; op_rd_en = '1; op_long = '0; op_reg = '0;
    rf_data[0] = 32'hA0A0_0001; rf_data[1] = 32'hB0B0_0002;
    p_valid = '0; p_wr = '0; p_fwd = '0; p_two = '0; p_long = '0; p_dst = '0;
    for (int k = 0; k < NSRC; k++) p_data[k] = 32'h1111_0000 * (k + 1) + 32'h0101 * (k + 3);
  endtask

  task automatic prod(input int k, input int dst, input bit lng, input bit fwd, input bit two);
    p_valid[k] = 1; p_wr[k] = 1; p_dst[k] = 4'(dst);
    p_long[k] = lng; p_fwd[k] = fwd; p_two[k] = two;
  endtask

  initial begin
    dec_valid = 0; op_rd_en = '0; op_long = '0; op_reg = '0; rf_data = '0;
    p_valid = '0; p_wr = '0; p_fwd = '0; p_two = '0; p_long = '0; p_dst = '0; p_data = '0;
    check("R9 idle passthrough");

    // R2 short-short exact match in stage 1 slot 0
    clear(); op_reg[0] = 4'd3; prod(2, 3, 0, 1, 0); check("R2");
    // R1 decode invalid, operand unread, write bit low
    clear(); op_reg = {4'd3, 4'd3}; prod(2, 3, 0, 1, 0); dec_valid = 0; check("R1 dec");
    clear(); op_reg = {4'd3, 4'd3}; prod(2, 3, 0, 1, 0); op_rd_en = 2'b10; check("R1 rd");
    clear(); op_reg[0] = 4'd3; prod(0, 3, 0, 1, 0); prod(4, 3, 0, 1, 0); p_wr[0] = 0; check("R1 wr");
    // R6 two-cycle in IX1 blocked (also shadows older), allowed in IX2
    clear(); op_reg[0] = 4'd6; prod(1, 6, 0, 1, 1); prod(4, 6, 0, 1, 0); check("R6 ix1");
    clear(); op_reg[0] = 4'd6; prod(3, 6, 1, 1, 1); op_long[0] = 1; check("R6 ix2");
    // R4 long operand vs short producer at odd partner
    clear(); op_long[0] = 1; op_reg[0] = 4'd4; prod(3, 5, 0, 1, 0); check("R4");
    // R3 short operand hits odd half of long producer, shadows older exact short
    clear(); op_reg[0] = 4'd5; prod(0, 4, 1, 1, 0); prod(5, 5, 0, 1, 0); check("R3");
    // R5 non-forwardable producer
    clear(); op_reg[1] = 4'd9; prod(2, 9, 0, 0, 0); check("R5");
    // R8 non-forwardable young hit shadows forwardable older
    clear(); op_reg[1] = 4'd9; prod(1, 9, 0, 0, 0); prod(3, 9, 0, 1, 0); check("R8");
    // R7 both slots of IX1, and IX2 versus IX3
    clear(); op_reg = {4'd2, 4'd2}; prod(0, 2, 0, 1, 0); prod(1, 2, 0, 1, 0); check("R7 slots");
    clear(); op_reg[1] = 4'd7; prod(3, 7, 0, 1, 0); prod(4, 7, 0, 1, 0); prod(2, 1, 0, 1, 0); check("R7 stages");
    // R9 long-long full data, both operands
    clear(); op_long = 2'b11; op_reg = {4'd8, 4'd10}; prod(5, 10, 1, 1, 0); prod(2, 8, 1, 1, 1); check("R9 long");

    // R10 random vectors with narrow id range
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #1;
      dec_valid = ($urandom_range(0, 9) != 0);
      op_rd_en = 2'($urandom); op_long = 2'($urandom);
      for (int op = 0; op < NOPS; op++) begin
        op_reg[op] = 4'($urandom_range(0, 5));
        rf_data[op] = $urandom;
      end
      for (int k = 0; k < NSRC; k++) begin
        p_valid[k] = ($urandom_range(0, 3) != 0); p_wr[k] = ($urandom_range(0, 4) != 0);
        p_fwd[k] = ($urandom_range(0, 3) != 0); p_two[k] = ($urandom_range(0, 2) == 0);
        p_long[k] = 1'($urandom); p_dst[k] = 4'($urandom_range(0, 5)); p_data[k] = $urandom;
      end
      check("R10 random");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule